// File: doc/BRIEF.md
# Sixteen-Bit Carry-Skip Adder

This block adds two unsigned operands and a carry input in a single combinational stage. Each operand bit first produces a generate term (both bits set) and a propagate term (bits differ). The word is split into groups of adjacent bits. Inside a group the carry ripples one bit at a time. A two-way multiplexer picks each group's carry-out. When every bit of the group propagates, the multiplexer passes the group's incoming carry straight through. Otherwise it takes the carry that rippled through the group. Each sum bit is the bit's propagate term XORed with the carry arriving at that bit.

The default layout is four groups of four bits. A packed parameter lists the group widths from least significant upward, eight bits per entry, so groups of unequal size can be built. A common choice is short groups at the two ends and longer ones in the middle. The carry out of the most significant group drives the final carry output. There are no registers.

Top module: `skip_adder`

## Requirements
- R1: For every operand pair and carry input, `sum` equals the low WIDTH bits of `op_a + op_b + c_in`.
- R2: `c_out` equals bit WIDTH of `op_a + op_b + c_in`. This is the carry leaving the most significant group.
- R3: When `op_b` is the bitwise inverse of `op_a`, every group fully propagates. With `c_in`=0 the result is `sum` all ones and `c_out`=0. With `c_in`=1 the result is `sum`=0 and `c_out`=1.
- R4: With both operands all ones, `sum` is all ones except bit 0, which equals `c_in`, and `c_out`=1.
- R5: With both operands zero, `sum` has `c_in` in bit 0 and zeros elsewhere, and `c_out`=0.
- R6: A carry generated in the lowest group passes through all higher groups whose bits all propagate. For example, `op_a`=16'hFFFF, `op_b`=16'h0001, `c_in`=0 gives `sum`=0 and `c_out`=1.
- R7: The group widths come from `GSIZES`, eight bits per group with the least significant group in the lowest byte, and must add up to WIDTH. With the unequal layout 3,5,5,3 the results still satisfy R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top group |

## Verification
The block holds no state. A wrong internal carry therefore appears at the ports at once, on the same input vector, as a wrong sum bit or carry output. A faulty skip multiplexer shows only when a group fully propagates and its incoming carry differs from its rippled carry. For that reason the stimulus forces whole-group propagate patterns and group-boundary carries, in addition to random operands. Running a second instance with unequal group widths exposes offset errors in the group boundaries.

// File: rtl/skip_adder.sv
module skip_adder #(
  parameter int WIDTH = 16,
  parameter int NGRP = 4,
  parameter logic [NGRP*8-1:0] GSIZES = {8'd4, 8'd4, 8'd4, 8'd4}
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out
);

  function automatic int grp_base(input int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += int'(GSIZES[k*8 +: 8]);
    return acc;
  endfunction

  logic [WIDTH-1:0] gen, prp, rip, cbit;
  logic [NGRP:0]    cgrp;

  assign gen = op_a & op_b;
  assign prp = op_a ^ op_b;
  assign cgrp[0] = c_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int BASE = grp_base(g);
    localparam int W = int'(GSIZES[g*8 +: 8]);
    logic gprop;
    for (genvar k = 0; k < W; k++) begin : g_bit
      if (k == 0) begin : g_first
        assign cbit[BASE] = cgrp[g];
      end else begin : g_next
        assign cbit[BASE+k] = rip[BASE+k-1];
      end
      assign rip[BASE+k] = gen[BASE+k] | (prp[BASE+k] & cbit[BASE+k]);
    end
    assign gprop = &prp[BASE +: W];
    assign cgrp[g+1] = gprop ? cgrp[g] : rip[BASE+W-1];
  end

  assign sum = prp ^ cbit;
  assign c_out = cgrp[NGRP];

endmodule

// File: rtl/skip_adder_chk.sv
module skip_adder_chk #(
  parameter int WIDTH = 16,
  parameter int NGRP = 4,
  parameter logic [NGRP*8-1:0] GSIZES = {8'd4, 8'd4, 8'd4, 8'd4}
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             c_in,
  input logic [WIDTH-1:0] sum,
  input logic             c_out
);

  function automatic int total_w();
    int acc;
    acc = 0;
    for (int k = 0; k < NGRP; k++) acc += int'(GSIZES[k*8 +: 8]);
    return acc;
  endfunction

  initial p_cfg_r7: assert (total_w() == WIDTH);

  logic [WIDTH:0] ref_v;
  assign ref_v = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, c_in};

  always_comb begin
    p_sum_r1: assert (sum == ref_v[WIDTH-1:0]);
    p_carry_r2: assert (c_out == ref_v[WIDTH]);
    if ((op_a ^ op_b) == '1) p_allprop_r3: assert (c_out == c_in && sum == {WIDTH{~c_in}});
    if (op_a == '1 && op_b == '1) p_ones_r4: assert (c_out && sum[WIDTH-1:1] == '1 && sum[0] == c_in);
    if (op_a == '0 && op_b == '0) p_zero_r5: assert (!c_out && sum == {{(WIDTH-1){1'b0}}, c_in});
  end

endmodule

bind skip_adder skip_adder_chk #(.WIDTH(WIDTH), .NGRP(NGRP), .GSIZES(GSIZES)) u_chk (
  .op_a(op_a), .op_b(op_b), .c_in(c_in), .sum(sum), .c_out(c_out)
);

// File: tb/test_skip_adder.sv
module test_skip_adder;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, s, s2;
  logic ci, co, co2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  skip_adder i_skip_adder (.op_a(a), .op_b(b), .c_in(ci), .sum(s), .c_out(co));
  skip_adder #(.GSIZES({8'd3, 8'd5, 8'd5, 8'd3})) i_skip_adder_var (
    .op_a(a), .op_b(b), .c_in(ci), .sum(s2), .c_out(co2));

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [W:0] exp_v);
    @(negedge clk);
    checks++;
    if ({co, s} !== exp_v) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, ci, {co, s}, exp_v);
    end
    checks++;
    if ({co2, s2} !== model(a, b, ci)) begin
      fails++;
      $display("FAIL R7 a=%h b=%h cin=%b got=%h exp=%h", a, b, ci, {co2, s2}, model(a, b, ci));
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string req,
                       input logic [W:0] exp_v);
    @(posedge clk);
    a = x; b = y; ci = c;
    check(req, exp_v);
  endtask

  initial begin
    logic [W-1:0] x, y;
    logic c;
    void'($urandom(32'd1234));
    a = '0; b = '0; ci = 1'b0;
    check("R5 initial", 17'h00000);
    apply('0, '0, 1'b1, "R5", 17'h00001);
    apply(16'h1234, ~16'h1234, 1'b0, "R3 cin0", 17'h0FFFF);
    apply(16'h1234, ~16'h1234, 1'b1, "R3 cin1", 17'h10000);
    apply(16'hA5C3, ~16'hA5C3, 1'b1, "R3 cin1", 17'h10000);
    apply('1, '1, 1'b0, "R4 cin0", 17'h1FFFE);
    apply('1, '1, 1'b1, "R4 cin1", 17'h1FFFF);
    apply(16'hFFFF, 16'h0001, 1'b0, "R6", 17'h10000);
    apply(16'hFFF0, 16'h000F, 1'b1, "R6 skip", 17'h10000);
    apply(16'h000F, 16'h0001, 1'b0, "R1 boundary", 17'h00010);
    apply(16'h8000, 16'h8000, 1'b0, "R2", 17'h10000);
    for (int g = 0; g < 4; g++) begin
      x = 16'h000F << (4 * g);
      apply(x, 16'h0001 << (4 * g), 1'b0, "R1 group", model(x, 16'h0001 << (4 * g), 1'b0));
    end
    for (int n = 0; n < 20000; n++) begin
      x = W'($urandom); y = W'($urandom); c = 1'($urandom);
      if (n % 4 == 1) y = ~x ^ (W'(1) << $urandom_range(W - 1));
      apply(x, y, c, "R1 R2 random", model(x, y, c));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule